// File: doc/BRIEF.md
# Triggered Scan Acquisition Controller

This block decides when a multi-channel, simultaneous-sampling acquisition engine takes a scan and whether that scan is kept. A scan interval timer, running on the block clock (the acquisition timebase), fires one scan-start strobe for all channels every `cfg_interval` clocks while scanning is active. A trigger strobe from outside steers a mode state machine. In pre-trigger mode, scans are kept until the trigger arrives. In middle-trigger mode, a fixed number of scans is also kept after it. In post-trigger mode, scanning starts only at the trigger. In delayed-trigger mode, a programmable number of scans runs unstored after the trigger before storing begins.

Each stored scan carries a tag that marks it as pre-trigger or post-trigger, along with a segment number. Re-triggering splits one armed run into several segments. After each segment the controller re-arms by itself until the configured number of segments has been captured, and then pulses `done`. A saturating count tells the buffer writer how many valid pre-trigger scans the current segment holds. An optional fill-first setting makes the controller refuse triggers until that many scans exist. A configuration with a zero in any counter that the chosen mode uses is rejected at arm time: the block stays idle and flags the error.

Top module: `scan_acq_ctrl`

## Requirements
- R1: On `arm` while idle, the block checks the configuration. If `cfg_interval` or `cfg_segments` is zero, or the mode uses `cfg_pre` (pre, middle), `cfg_post` (post, middle, delay) or `cfg_delay` (delay) and that value is zero, it sets `cfg_err`, stays idle and strobes no scan. A valid arm clears `cfg_err`. After reset all outputs are low.
- R2: While scanning, `scan_start` pulses once every `cfg_interval` clocks, with no break across the change from pre to post phase or from delay to post phase. Every `store_en` pulse coincides with a `scan_start` pulse.
- R3: Post mode (`cfg_mode`=0): scanning begins at the accepted trigger. The first stored scan appears `cfg_interval` clocks after the clock edge that samples the trigger. Exactly `cfg_post` scans are stored, all with `scan_pre` low.
- R4: Pre mode (`cfg_mode`=1): scanning starts one interval after arm. Every scan is stored with `scan_pre` high, up to and including a scan on the trigger edge. The accepted trigger ends the segment. `pre_count` counts the scans of the segment and saturates at `cfg_pre`.
- R5: With `cfg_fill_first` set, a trigger in pre or middle mode is ignored while fewer than `cfg_pre` scans of the current segment have been taken before that clock edge.
- R6: Middle mode (`cfg_mode`=2): pre-trigger scans are stored as in R4. After the accepted trigger, exactly `cfg_post` further scans are stored with `scan_pre` low, at an unbroken cadence.
- R7: Delayed mode (`cfg_mode`=3): after the trigger, `cfg_delay` scans are strobed but not stored. The next `cfg_post` scans are stored, the first one `(cfg_delay+1)*cfg_interval` clocks after the trigger edge.
- R8: A run captures `cfg_segments` segments, one per accepted trigger. `seg_tag` carries the segment number (0, 1, ...) of each stored scan. Between segments the block re-arms without a new `arm`.
- R9: A trigger while idle, during the delay phase or during the post phase has no effect.
- R10: `done` is a one-cycle pulse. It comes with the last stored scan of the final segment, or, in pre mode, one cycle after the final accepted trigger. `busy` falls in the same cycle.
- R11: The configuration is latched at arm. Changes to `cfg_*` during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a run (sampled while idle) |
| trig | input | 1 | Trigger strobe |
| cfg_mode | input | 2 | 0 post, 1 pre, 2 middle, 3 delayed |
| cfg_interval | input | IVL_W | Clocks per scan |
| cfg_pre | input | CNT_W | Pre-trigger scan count M |
| cfg_post | input | CNT_W | Post-trigger scan count N |
| cfg_delay | input | CNT_W | Unstored scans after trigger (delayed mode) |
| cfg_segments | input | SEG_W | Segments per run |
| cfg_fill_first | input | 1 | Refuse triggers until M scans taken |
| scan_start | output | 1 | Scan strobe to all channels |
| store_en | output | 1 | Keep this scan |
| scan_pre | output | 1 | Stored scan is pre-trigger |
| seg_tag | output | SEG_W | Segment number of the stored scan |
| pre_count | output | CNT_W | Valid pre-trigger scans, saturating at M |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished pulse |
| cfg_err | output | 1 | Last arm rejected |

## Verification
The bound checker checks these rules on every cycle: a store always coincides with a scan strobe; a pre tag always coincides with a store; `pre_count` never exceeds the latched M; segment tags stay below the latched segment count; `done` is a lone pulse taken while idle; and an error flag never coexists with a running capture. The other behaviours depend on counts and latencies across whole runs, so only the bench scenarios can show them. These are the exact number of stored and unstored scans per mode, the trigger-to-first-store latency, the cadence spacing, the refusal of early triggers under fill-first, triggers ignored mid-run, segment numbering across re-triggers, and that configuration changes during a run have no effect.

// File: rtl/scan_acq_pkg.sv
package scan_acq_pkg;
  typedef enum logic [1:0] {
    MODE_POST  = 2'd0,
    MODE_PRE   = 2'd1,
    MODE_MID   = 2'd2,
    MODE_DELAY = 2'd3
  } trig_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_DELAY,
    ST_POST
  } acq_state_e;

  function automatic logic mode_uses_pre(input trig_mode_e m);
    return (m == MODE_PRE) || (m == MODE_MID);
  endfunction

  function automatic logic mode_uses_post(input trig_mode_e m);
    return m != MODE_PRE;
  endfunction
endpackage

// File: rtl/scan_interval_timer.sv
module scan_interval_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [IVL_W-1:0] period,
  output logic             tick
);
  logic [IVL_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == period - 1'b1);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scan_down_counter.sv
module scan_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         last
);
  assign last = (value == W'(1));

  always_ff @(posedge clk) begin
    if (rst)                    value <= '0;
    else if (load)              value <= load_val;
    else if (dec && value != 0) value <= value - 1'b1;
  end
endmodule

// File: rtl/scan_sat_counter.sv
module scan_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value,
  output logic         full
);
  assign full = (value >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr)        value <= '0;
    else if (inc && !full) value <= value + 1'b1;
  end
endmodule

// File: rtl/scan_acq_ctrl.sv
module scan_acq_ctrl
  import scan_acq_pkg::*;
#(
  parameter int IVL_W = 16,
  parameter int CNT_W = 16,
  parameter int SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             trig,
  input  logic [1:0]       cfg_mode,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [SEG_W-1:0] cfg_segments,
  input  logic             cfg_fill_first,
  output logic             scan_start,
  output logic             store_en,
  output logic             scan_pre,
  output logic [SEG_W-1:0] seg_tag,
  output logic [CNT_W-1:0] pre_count,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);
  acq_state_e st, st_nxt;
  trig_mode_e in_mode;

  // configuration latched at arm
  trig_mode_e       lat_mode;
  logic [IVL_W-1:0] lat_ivl;
  logic [CNT_W-1:0] lat_pre, lat_post, lat_dly;
  logic [SEG_W-1:0] lat_segs;
  logic             lat_fill;

  logic [SEG_W-1:0] seg_cnt;
  logic             cfg_bad, arm_ok;
  logic             tick, run;
  logic             pre_full, post_last, dly_last;
  logic [CNT_W-1:0] post_val, dly_val;
  logic             trig_take, seg_end, final_end;
  logic             post_load, dly_load, pre_clr;

  assign in_mode = trig_mode_e'(cfg_mode);

  always_comb begin
    cfg_bad = (cfg_interval == '0) || (cfg_segments == '0);
    if (mode_uses_pre(in_mode)  && cfg_pre   == '0) cfg_bad = 1'b1;
    if (mode_uses_post(in_mode) && cfg_post  == '0) cfg_bad = 1'b1;
    if (in_mode == MODE_DELAY   && cfg_delay == '0) cfg_bad = 1'b1;
  end

  assign arm_ok = (st == ST_IDLE) && arm && !cfg_bad;
  assign run    = (st == ST_PRE) || (st == ST_DELAY) || (st == ST_POST);

  scan_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .period(lat_ivl), .tick(tick)
  );

  assign trig_take = trig && ((st == ST_WAIT) ||
                              (st == ST_PRE && (!lat_fill || pre_full)));

  assign seg_end   = (st == ST_PRE && trig_take && lat_mode == MODE_PRE) ||
                     (st == ST_POST && tick && post_last);
  assign final_end = seg_end && (seg_cnt == lat_segs - 1'b1);

  assign post_load = (st == ST_WAIT && trig_take && lat_mode != MODE_DELAY) ||
                     (st == ST_PRE && trig_take && lat_mode == MODE_MID) ||
                     (st == ST_DELAY && tick && dly_last);
  assign dly_load  = (st == ST_WAIT && trig_take && lat_mode == MODE_DELAY);
  assign pre_clr   = arm_ok || (seg_end && !final_end);

  scan_down_counter #(.W(CNT_W)) u_post_cnt (
    .clk(clk), .rst(rst), .load(post_load), .load_val(lat_post),
    .dec(st == ST_POST && tick), .value(post_val), .last(post_last)
  );

  scan_down_counter #(.W(CNT_W)) u_dly_cnt (
    .clk(clk), .rst(rst), .load(dly_load), .load_val(lat_dly),
    .dec(st == ST_DELAY && tick), .value(dly_val), .last(dly_last)
  );

  scan_sat_counter #(.W(CNT_W)) u_pre_cnt (
    .clk(clk), .rst(rst), .clr(pre_clr), .inc(st == ST_PRE && tick),
    .limit(lat_pre), .value(pre_count), .full(pre_full)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (arm_ok) st_nxt = mode_uses_pre(in_mode) ? ST_PRE : ST_WAIT;
      ST_WAIT:  if (trig_take) st_nxt = (lat_mode == MODE_DELAY) ? ST_DELAY : ST_POST;
      ST_PRE:   if (trig_take) begin
                  if (lat_mode == MODE_MID) st_nxt = ST_POST;
                  else if (final_end)       st_nxt = ST_IDLE;
                end
      ST_DELAY: if (tick && dly_last) st_nxt = ST_POST;
      ST_POST:  if (seg_end) begin
                  if (final_end)                   st_nxt = ST_IDLE;
                  else if (mode_uses_pre(lat_mode)) st_nxt = ST_PRE;
                  else                              st_nxt = ST_WAIT;
                end
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      lat_mode <= MODE_POST;
      lat_ivl  <= '0;
      lat_pre  <= '0;
      lat_post <= '0;
      lat_dly  <= '0;
      lat_segs <= '0;
      lat_fill <= 1'b0;
      seg_cnt  <= '0;
      cfg_err  <= 1'b0;
    end else begin
      st <= st_nxt;
      if (st == ST_IDLE && arm) cfg_err <= cfg_bad;
      if (arm_ok) begin
        lat_mode <= in_mode;
        lat_ivl  <= cfg_interval;
        lat_pre  <= cfg_pre;
        lat_post <= cfg_post;
        lat_dly  <= cfg_delay;
        lat_segs <= cfg_segments;
        lat_fill <= cfg_fill_first;
        seg_cnt  <= '0;
      end else if (seg_end && !final_end) begin
        seg_cnt <= seg_cnt + 1'b1;
      end
    end
  end

  // registered strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_start <= 1'b0;
      store_en   <= 1'b0;
      scan_pre   <= 1'b0;
      seg_tag    <= '0;
      done       <= 1'b0;
    end else begin
      scan_start <= tick;
      store_en   <= tick && (st == ST_PRE || st == ST_POST);
      scan_pre   <= tick && (st == ST_PRE);
      done       <= final_end;
      if (tick) seg_tag <= seg_cnt;
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/scan_acq_ctrl_chk.sv
module scan_acq_ctrl_chk #(
  parameter int CNT_W = 16,
  parameter int SEG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             scan_start,
  input logic             store_en,
  input logic             scan_pre,
  input logic [SEG_W-1:0] seg_tag,
  input logic [CNT_W-1:0] pre_count,
  input logic             busy,
  input logic             done,
  input logic             cfg_err,
  input logic [CNT_W-1:0] lat_pre,
  input logic [SEG_W-1:0] lat_segs
);
  p_store_with_scan_r2: assert property (@(posedge clk) disable iff (rst)
    store_en |-> scan_start);

  p_pre_tag_stored_r4: assert property (@(posedge clk) disable iff (rst)
    scan_pre |-> store_en);

  p_pre_saturates_r4: assert property (@(posedge clk) disable iff (rst)
    pre_count <= lat_pre);

  p_error_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);

  p_seg_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    store_en |-> (seg_tag < lat_segs));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind scan_acq_ctrl scan_acq_ctrl_chk #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst(rst), .scan_start(scan_start), .store_en(store_en),
  .scan_pre(scan_pre), .seg_tag(seg_tag), .pre_count(pre_count),
  .busy(busy), .done(done), .cfg_err(cfg_err),
  .lat_pre(lat_pre), .lat_segs(lat_segs)
);

// File: tb/scan_acq_ctrl_test.sv
module scan_acq_ctrl_test;
  localparam int IVL_W = 16;
  localparam int CNT_W = 16;
  localparam int SEG_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0, trig = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [IVL_W-1:0] cfg_interval = '0;
  logic [CNT_W-1:0] cfg_pre = '0, cfg_post = '0, cfg_delay = '0;
  logic [SEG_W-1:0] cfg_segments = '0;
  logic cfg_fill_first = 1'b0;
  logic scan_start, store_en, scan_pre, busy, done, cfg_err;
  logic [SEG_W-1:0] seg_tag;
  logic [CNT_W-1:0] pre_count;

  always #5 clk = ~clk;

  scan_acq_ctrl #(.IVL_W(IVL_W), .CNT_W(CNT_W), .SEG_W(SEG_W)) uut (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .cfg_mode(cfg_mode),
    .cfg_interval(cfg_interval), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .cfg_delay(cfg_delay), .cfg_segments(cfg_segments),
    .cfg_fill_first(cfg_fill_first), .scan_start(scan_start),
    .store_en(store_en), .scan_pre(scan_pre), .seg_tag(seg_tag),
    .pre_count(pre_count), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  int total = 0, bad = 0;
  int cyc = 0, tcyc = 0;
  int n_scan, n_unst, n_pre, n_post, n_s0, n_s1, n_done, first_lat;
  int last_scan, gap_bad, gap_exp;
  bit have_last, chk_gap;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (scan_start) begin
      n_scan++;
      if (!store_en) n_unst++;
      if (chk_gap && have_last && (cyc - last_scan) != gap_exp) gap_bad++;
      last_scan = cyc;
      have_last = 1'b1;
    end
    if (store_en) begin
      if (scan_pre) n_pre++;
      else begin
        n_post++;
        if (first_lat < 0) first_lat = cyc - tcyc;
      end
      if (seg_tag == 0) n_s0++;
      else if (seg_tag == 1) n_s1++;
    end
    if (done) n_done++;
  end

  task automatic clear_mon();
    n_scan = 0; n_unst = 0; n_pre = 0; n_post = 0; n_s0 = 0; n_s1 = 0;
    n_done = 0; first_lat = -1; gap_bad = 0; have_last = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse_trig(input int after);
    repeat (after - 1) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    tcyc = cyc;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy && k < 3000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 3000) chk({req, " timeout"}, 1, 0);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input int ivl, input int pre,
                         input int post, input int dly, input int segs,
                         input bit fill);
    cfg_mode = m; cfg_interval = IVL_W'(ivl); cfg_pre = CNT_W'(pre);
    cfg_post = CNT_W'(post); cfg_delay = CNT_W'(dly);
    cfg_segments = SEG_W'(segs); cfg_fill_first = fill;
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] ivl;
    logic [15:0] pre;
    logic [15:0] post;
    logic [15:0] dly;
    logic [15:0] w;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{2'd0, 16'd3, 16'd0, 16'd4, 16'd0, 16'd2},
    '{2'd0, 16'd1, 16'd0, 16'd1, 16'd0, 16'd1},
    '{2'd3, 16'd2, 16'd0, 16'd3, 16'd2, 16'd4},
    '{2'd1, 16'd2, 16'd3, 16'd0, 16'd0, 16'd9},
    '{2'd1, 16'd4, 16'd5, 16'd0, 16'd0, 16'd9},
    '{2'd2, 16'd3, 16'd2, 16'd2, 16'd0, 16'd7},
    '{2'd3, 16'd1, 16'd0, 16'd2, 16'd1, 16'd3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mon();
    chk_gap = 1'b0; gap_exp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset strobes", int'(scan_start | store_en | done | cfg_err), 0);

    // table walk: one segment per vector
    for (int i = 0; i < 7; i++) begin
      int ivl, pre, post, dly, w, e_pre, e_post, e_unst, e_lat, e_pc;
      ivl = int'(TBL[i].ivl); pre = int'(TBL[i].pre); post = int'(TBL[i].post);
      dly = int'(TBL[i].dly); w = int'(TBL[i].w);
      e_pre  = (TBL[i].mode == 2'd1 || TBL[i].mode == 2'd2) ? w / ivl : 0;
      e_post = (TBL[i].mode == 2'd1) ? 0 : post;
      e_unst = (TBL[i].mode == 2'd3) ? dly : 0;
      e_lat  = (TBL[i].mode == 2'd3) ? (dly + 1) * ivl : ivl;
      e_pc   = (e_pre < pre) ? e_pre : pre;
      set_cfg(TBL[i].mode, ivl, pre, post, dly, 1, 1'b0);
      clear_mon();
      chk_gap = 1'b1; gap_exp = ivl;
      do_arm();
      pulse_trig(w);
      wait_idle("R10");
      case (TBL[i].mode)
        2'd0: begin
          chk("R3 post stores", n_post, e_post);
          chk("R3 post latency", first_lat, e_lat);
          chk("R3 no pre tags", n_pre, 0);
        end
        2'd1: begin
          chk("R4 pre stores", n_pre, e_pre);
          chk("R4 pre_count", int'(pre_count), e_pc);
          chk("R4 no post", n_post, 0);
        end
        2'd2: begin
          chk("R6 mid pre", n_pre, e_pre);
          chk("R6 mid post", n_post, e_post);
        end
        default: begin
          chk("R7 unstored", n_unst, e_unst);
          chk("R7 stored", n_post, e_post);
          chk("R7 latency", first_lat, e_lat);
        end
      endcase
      chk("R2 cadence gaps", gap_bad, 0);
      chk("R10 done pulses", n_done, 1);
    end
    chk_gap = 1'b0;

    // R1: zero interval rejected
    set_cfg(2'd0, 0, 0, 4, 0, 1, 1'b0);
    clear_mon();
    do_arm();
    pulse_trig(3);
    repeat (10) @(negedge clk);
    chk("R1 err flag", int'(cfg_err), 1);
    chk("R1 idle", int'(busy), 0);
    chk("R1 no scans", n_scan, 0);
    // R1: middle mode with zero post rejected
    set_cfg(2'd2, 2, 2, 0, 0, 1, 1'b0);
    do_arm();
    repeat (8) @(negedge clk);
    chk("R1 mid zero post", int'(cfg_err), 1);
    chk("R1 mid no scans", n_scan, 0);
    // R1: valid arm clears error
    set_cfg(2'd0, 2, 0, 1, 0, 1, 1'b0);
    do_arm();
    chk("R1 err cleared", int'(cfg_err), 0);
    pulse_trig(2);
    wait_idle("R1");

    // R9: trigger while idle
    clear_mon();
    pulse_trig(2);
    repeat (10) @(negedge clk);
    chk("R9 idle trig busy", int'(busy), 0);
    chk("R9 idle trig scans", n_scan, 0);

    // R5: fill-first, pre mode I=4 M=3
    set_cfg(2'd1, 4, 3, 0, 0, 1, 1'b1);
    clear_mon();
    do_arm();
    pulse_trig(5);
    repeat (2) @(negedge clk);
    chk("R5 early trig ignored", int'(busy), 1);
    pulse_trig(13);
    wait_idle("R5");
    chk("R5 pre stores", n_pre, 5);
    chk("R5 pre_count sat", int'(pre_count), 3);

    // R8 + R9: post re-trigger, two segments, mid-run trigger ignored
    set_cfg(2'd0, 2, 0, 3, 0, 2, 1'b0);
    clear_mon();
    do_arm();
    pulse_trig(3);
    pulse_trig(2);
    repeat (12) @(negedge clk);
    chk("R9 mid-run trig seg0", n_s0, 3);
    chk("R8 rearm busy", int'(busy), 1);
    pulse_trig(3);
    wait_idle("R8");
    chk("R8 seg1 stores", n_s1, 3);
    chk("R8 total stores", n_post, 6);
    chk("R10 done once", n_done, 1);

    // R8: pre mode two segments, cadence continues
    set_cfg(2'd1, 3, 2, 0, 0, 2, 1'b0);
    clear_mon();
    do_arm();
    pulse_trig(7);
    pulse_trig(5);
    wait_idle("R8");
    chk("R8 pre seg0", n_s0, 2);
    chk("R8 pre seg1", n_s1, 2);
    chk("R10 pre done", n_done, 1);

    // R11: config changed during run
    set_cfg(2'd0, 2, 0, 2, 0, 1, 1'b0);
    clear_mon();
    chk_gap = 1'b1; gap_exp = 2;
    do_arm();
    cfg_post = CNT_W'(7); cfg_interval = IVL_W'(5); cfg_mode = 2'd1;
    pulse_trig(2);
    wait_idle("R11");
    chk("R11 latched post", n_post, 2);
    chk("R11 latched interval", gap_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule